// File: doc/BRIEF.md
# Smart-Card Serial Unit with Parity Error Signalling

This block is a half-duplex asynchronous serial unit for a single-wire smart-card link. The card's I/O wire is tied to both the block's receive input and its open-drain transmit output. Character frames are built and taken apart on a baud tick that runs at sixteen times the bit rate. If a received character fails its even-parity test and error signalling is enabled, the unit pulls the shared wire low. The low pulse starts at the middle of the stop bit and lasts one bit time, so the card knows it must resend. A read of the received byte ends the pulse early.

When the unit sends, it raises a one-cycle completion pulse at the baud tick that closes the stop bit. At that moment the synchronised level of the wire is on an output, so the host can see whether the card is answering with its own error pulse. The receiver is held idle while the transmitter is busy, and it stays idle until it has seen the wire high again. This keeps it from decoding its own echo or the card's error pulse.

The receiver has six states:
- RX_IDLE waits for a falling edge.
- RX_START checks the start bit at mid-bit.
- RX_DATA collects eight bits.
- RX_PARITY samples the parity bit.
- RX_STOP completes the frame at the middle of the stop bit.
- RX_ERRSIG drives the error pulse.

Its transitions are IDLE→START on an armed falling edge, START→IDLE on a rejected start, START→DATA, DATA→PARITY after the last bit, PARITY→STOP, STOP→ERRSIG or STOP→IDLE, and ERRSIG→IDLE on timeout, read or disable. Any state goes to IDLE while the transmitter is busy.

The transmitter has five states: TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. Its transitions are IDLE→START on a write, START→DATA, DATA→PARITY after the last bit, PARITY→STOP, and STOP→IDLE with the completion pulse.

Top module: `scu_uart`

## Requirements
- R1: A transmitted frame is one start bit (0), eight data bits least-significant first, one even-parity bit (the XOR of the data bits) and one stop bit (1). Each bit lasts 16 baud ticks, and the start bit ends at the 16th tick after the write. `line_pull_low` = 1 means the wire is driven low.
- R2: A transmit write made while `tx_busy` is 1 is ignored, and the frame in progress continues unchanged.
- R3: `tx_done` is a one-cycle pulse that becomes visible right after the baud tick ending the stop bit, which is the 176th tick after the write. At that point `tx_busy` is 0.
- R4: `rx_level` shows the synchronised level of the wire. The receiver ignores the wire while transmitting, and afterwards until the wire has been seen high.
- R5: Each received bit is taken as the majority of three samples around mid-bit. This rejects a one-tick glitch. A completed byte appears on `rx_data` with `rx_valid` = 1.
- R6: A falling edge whose line is high again at mid-start-bit is discarded, and no byte is produced.
- R7: `parity_err` is set with the received byte when the data bits and the parity bit together hold an odd number of ones.
- R8: With `err_sig_en` = 1 and a parity error, `line_pull_low` is 1 for exactly 16 baud ticks starting at mid-stop-bit. With `err_sig_en` = 0 it is never driven by the receiver.
- R9: A `rd_strobe` clears `rx_valid`, `parity_err` and `overrun`, and in the next cycle releases any error pulse.
- R10: A byte that completes while `rx_valid` is still 1 sets `overrun` and is discarded, and `rx_data` keeps the earlier byte.
- R11: After reset, `line_pull_low`, `rx_valid`, `parity_err`, `overrun`, `tx_busy` and `tx_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| err_sig_en | input | 1 | Enables parity error signalling |
| line_in | input | 1 | Level of the shared card wire |
| line_pull_low | output | 1 | Open-drain enable: 1 drives the wire low |
| rx_level | output | 1 | Synchronised wire level |
| rd_strobe | input | 1 | Read of the received byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte not yet read |
| parity_err | output | 1 | Received byte had bad parity |
| overrun | output | 1 | A byte was lost to an unread one |
| tx_wr | input | 1 | Write of a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | Frame being sent |
| tx_done | output | 1 | Transmit-finished pulse |

## Verification
The assertions check these rules on every cycle:
- a receiver-driven low only ever appears with a flagged, unread bad-parity byte;
- a read always releases the wire and clears the flags;
- the completion pulse is single and only occurs when idle;
- every frame starts low right after a write;
- an unread byte never changes.

The exact bit values on the wire, the 16-tick length of the error pulse, majority filtering of glitches, start rejection and echo suppression depend on timed stimulus from the card side. Only the bench scenarios show these.

// File: rtl/scu_pkg.sv
package scu_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_ERRSIG
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    // two-of-three vote
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/scu_rx.sv
module scu_rx
    import scu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_s,
    input  logic              hold,
    input  logic              err_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              overrun,
    output logic              err_drive,
    output logic              frame_done
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] ENDC = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic [1:0]        hist_q;
    logic              par_q;
    logic              armed_q;
    logic              sample;
    logic              mid_tick;
    logic              end_tick;
    logic              can_load;

    assign sample     = vote3(hist_q[1], hist_q[0], line_s);
    assign mid_tick   = tick && (cnt_q == MID);
    assign end_tick   = tick && (cnt_q == ENDC);
    assign can_load   = !rx_valid || rd_strobe;
    assign frame_done = (state_q == RX_STOP) && mid_tick && !hold;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (tick && armed_q && !line_s) state_d = RX_START;
            end
            RX_START: begin
                if (mid_tick && sample)  state_d = RX_IDLE;
                else if (end_tick)       state_d = RX_DATA;
            end
            RX_DATA: begin
                if (end_tick && (bit_q == LAST)) state_d = RX_PARITY;
            end
            RX_PARITY: begin
                if (end_tick) state_d = RX_STOP;
            end
            RX_STOP: begin
                if (mid_tick)
                    state_d = (par_q && err_en && can_load) ? RX_ERRSIG : RX_IDLE;
            end
            RX_ERRSIG: begin
                if (rd_strobe || !err_en || end_tick) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
        if (hold) state_d = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // bit timing and shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            hist_q  <= 2'b11;
            par_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (tick) hist_q <= {hist_q[0], line_s};
            if (hold)      armed_q <= 1'b0;
            else if (tick) armed_q <= line_s;
            if (tick) begin
                if (state_q == RX_IDLE || state_d != state_q || cnt_q == ENDC)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == RX_IDLE) begin
                bit_q <= '0;
                par_q <= 1'b0;
            end
            if (state_q == RX_DATA && mid_tick) begin
                shreg_q <= {sample, shreg_q[DATA_W-1:1]};
                par_q   <= par_q ^ sample;
            end
            if (state_q == RX_DATA && end_tick) bit_q <= bit_q + 1'b1;
            if (state_q == RX_PARITY && mid_tick) par_q <= par_q ^ sample;
        end
    end

    // host-visible flags and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (rd_strobe) begin
                rx_valid   <= 1'b0;
                parity_err <= 1'b0;
                overrun    <= 1'b0;
            end
            if (frame_done) begin
                if (can_load) begin
                    rx_data    <= shreg_q;
                    rx_valid   <= 1'b1;
                    parity_err <= par_q;
                end else begin
                    overrun <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        err_drive = (state_q == RX_ERRSIG);
    end

endmodule

// File: rtl/scu_tx.sv
module scu_tx
    import scu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              drive_low
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] ENDC = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              done_q;
    logic              end_tick;

    assign end_tick = tick && (cnt_q == ENDC);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (wr)       state_d = TX_START;
            TX_START:  if (end_tick) state_d = TX_DATA;
            TX_DATA:   if (end_tick && (bit_q == LAST)) state_d = TX_PARITY;
            TX_PARITY: if (end_tick) state_d = TX_STOP;
            TX_STOP:   if (end_tick) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == TX_STOP) && end_tick;
            if (state_q == TX_IDLE) begin
                cnt_q <= '0;
                bit_q <= '0;
                if (wr) begin
                    shreg_q <= wdata;
                    par_q   <= ^wdata;
                end
            end else if (tick) begin
                cnt_q <= (cnt_q == ENDC) ? '0 : cnt_q + 1'b1;
                if (state_q == TX_DATA && cnt_q == ENDC) begin
                    bit_q   <= bit_q + 1'b1;
                    shreg_q <= shreg_q >> 1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != TX_IDLE);
        done = done_q;
        unique case (state_q)
            TX_START:  drive_low = 1'b1;
            TX_DATA:   drive_low = !shreg_q[0];
            TX_PARITY: drive_low = !par_q;
            default:   drive_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/scu_uart.sv
module scu_uart
    import scu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              err_sig_en,
    input  logic              line_in,
    output logic              line_pull_low,
    output logic              rx_level,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              overrun,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_busy,
    output logic              tx_done
);

    logic line_s;
    logic rx_err_drive;
    logic rx_frame_done;
    logic tx_low;

    generate
        if (SYNC_STAGES <= 1) begin : g_sync1
            logic sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= line_in;
            end
            assign line_s = sync_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            end
            assign line_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    scu_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .line_s     (line_s),
        .hold       (tx_busy),
        .err_en     (err_sig_en),
        .rd_strobe  (rd_strobe),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .parity_err (parity_err),
        .overrun    (overrun),
        .err_drive  (rx_err_drive),
        .frame_done (rx_frame_done)
    );

    scu_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .wr        (tx_wr),
        .wdata     (tx_data),
        .busy      (tx_busy),
        .done      (tx_done),
        .drive_low (tx_low)
    );

    assign line_pull_low = tx_low | rx_err_drive;
    assign rx_level      = line_s;

endmodule

// File: rtl/scu_uart_chk.sv
module scu_uart_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_pull_low,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              parity_err,
    input logic              overrun,
    input logic              tx_wr,
    input logic              tx_busy,
    input logic              tx_done,
    input logic              rx_frame_done
);

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> line_pull_low); // R1

    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_wr)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done); // R3

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !tx_busy); // R3

    AST_PERR_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> rx_valid); // R7

    AST_PULL_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pull_low && !tx_busy) |-> (parity_err && rx_valid)); // R8

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !tx_busy && !tx_wr && !rx_frame_done)
        |=> (!line_pull_low && !parity_err && !rx_valid && !overrun)); // R9

    AST_UNREAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_strobe) |=> ($stable(rx_data) && rx_valid)); // R10

    AST_OVR_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rx_valid); // R10

endmodule

bind scu_uart scu_uart_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_pull_low (line_pull_low),
    .rd_strobe     (rd_strobe),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .parity_err    (parity_err),
    .overrun       (overrun),
    .tx_wr         (tx_wr),
    .tx_busy       (tx_busy),
    .tx_done       (tx_done),
    .rx_frame_done (rx_frame_done)
);

// File: tb/scu_uart_bench.sv
`timescale 1ns/1ps
module scu_uart_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_q = 2'd0;
    logic       baud_tick;
    int         tick_cnt = 0;
    int         pull_total = 0;
    logic       err_sig_en = 1'b0;
    logic       card_low = 1'b0;
    logic       line_in;
    logic       line_pull_low;
    logic       rx_level;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       parity_err;
    logic       overrun;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_busy;
    logic       tx_done;
    int         checks = 0;
    int         fails = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    assign baud_tick = (div_q == 2'd3);
    assign line_in   = !(line_pull_low || card_low);

    always @(posedge clk) begin
        div_q <= div_q + 2'd1;
        if (baud_tick) tick_cnt <= tick_cnt + 1;
        if (line_pull_low && !tx_busy) pull_total <= pull_total + 1;
    end

    scu_uart u_scu_uart (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .err_sig_en(err_sig_en),
        .line_in(line_in), .line_pull_low(line_pull_low), .rx_level(rx_level),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_valid(rx_valid),
        .parity_err(parity_err), .overrun(overrun), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done)
    );

    function automatic bit frame_bit(input logic [7:0] d, input bit bad, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (i == 9) return (^d) ^ bad;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_until(input int t);
        while (tick_cnt < t) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        wait_until(tick_cnt + n);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic card_send(input logic [7:0] d, input bit bad, input int glitch_idx);
        for (int i = 0; i < 11; i++) begin
            if (glitch_idx == i && frame_bit(d, bad, i)) begin
                card_low = 1'b0; wait_ticks(7);
                card_low = 1'b1; wait_ticks(1);
                card_low = 1'b0; wait_ticks(8);
            end else begin
                card_low = !frame_bit(d, bad, i);
                wait_ticks(16);
            end
        end
        card_low = 1'b0;
    endtask

    task automatic tx_frame(input logic [7:0] d, input bit card_err, input bit overwrite);
        int t0;
        int n;
        wait_ticks(1);
        tx_wr = 1'b1; tx_data = d; t0 = tick_cnt;
        @(negedge clk);
        tx_wr = 1'b0;
        for (int i = 0; i < 11; i++) begin
            wait_until(t0 + 16 * i + 8);
            chk(overwrite && i > 3 ? "R2" : "R1", $sformatf("tx bit %0d", i),
                int'(line_pull_low), int'(!frame_bit(d, 1'b0, i)));
            if (overwrite && i == 3) begin
                tx_wr = 1'b1; tx_data = ~d;
                @(negedge clk);
                tx_wr = 1'b0;
            end
        end
        if (card_err) card_low = 1'b1;
        n = 0;
        while (!tx_done && n < 400) begin @(negedge clk); n++; end
        chk("R3", "done tick", tick_cnt - t0, 176);
        chk("R3", "idle at done", int'(tx_busy), 0);
        chk("R4", "rx_level at done", int'(rx_level), int'(!card_err));
        @(negedge clk);
        chk("R3", "done single", int'(tx_done), 0);
        wait_until(t0 + 184);
        card_low = 1'b0;
        wait_ticks(200);
        chk("R4", "no echo byte", int'(rx_valid), 0);
    endtask

    initial begin
        #(160000 * 4);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int p0;
        logic [7:0] d;
        bit bad;
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        // R11 reset state
        chk("R11", "pull", int'(line_pull_low), 0);
        chk("R11", "valid", int'(rx_valid), 0);
        chk("R11", "perr", int'(parity_err), 0);
        chk("R11", "ovr", int'(overrun), 0);
        chk("R11", "busy", int'(tx_busy), 0);
        chk("R11", "done", int'(tx_done), 0);
        rst_n = 1'b1;
        wait_ticks(20);

        // R5 good byte
        err_sig_en = 1'b1;
        card_send(8'hA5, 1'b0, -1);
        chk("R5", "valid", int'(rx_valid), 1);
        chk("R5", "data", int'(rx_data), 8'hA5);
        chk("R7", "perr good", int'(parity_err), 0);
        do_read();
        chk("R9", "valid cleared", int'(rx_valid), 0);
        wait_ticks(20);

        // R8 full error window, enabled
        p0 = pull_total;
        card_send(8'h3C, 1'b1, -1);
        chk("R7", "perr bad", int'(parity_err), 1);
        chk("R5", "data bad frame", int'(rx_data), 8'h3C);
        wait_ticks(16);
        chk("R8", "window clocks", pull_total - p0, 64);
        do_read();
        wait_ticks(20);

        // R8 disabled
        err_sig_en = 1'b0;
        p0 = pull_total;
        card_send(8'h5A, 1'b1, -1);
        wait_ticks(16);
        chk("R8", "no pulse when off", pull_total - p0, 0);
        chk("R7", "perr when off", int'(parity_err), 1);
        do_read();
        wait_ticks(20);

        // R9 early release
        err_sig_en = 1'b1;
        card_send(8'h81, 1'b1, -1);
        chk("R8", "pulse active", int'(line_pull_low), 1);
        do_read();
        chk("R9", "released", int'(line_pull_low), 0);
        chk("R9", "perr cleared", int'(parity_err), 0);
        wait_ticks(20);

        // R10 overrun
        card_send(8'h11, 1'b0, -1);
        wait_ticks(4);
        card_send(8'h22, 1'b0, -1);
        chk("R10", "overrun", int'(overrun), 1);
        chk("R10", "kept byte", int'(rx_data), 8'h11);
        do_read();
        chk("R9", "overrun cleared", int'(overrun), 0);
        wait_ticks(20);

        // R6 false start
        card_low = 1'b1; wait_ticks(3); card_low = 1'b0;
        wait_ticks(200);
        chk("R6", "false start", int'(rx_valid), 0);

        // R5 glitch filtered
        card_send(8'hFF, 1'b0, 4);
        chk("R5", "glitch data", int'(rx_data), 8'hFF);
        chk("R5", "glitch perr", int'(parity_err), 0);
        do_read();
        wait_ticks(20);

        // transmit: R1 R2 R3 R4
        tx_frame(8'h96, 1'b0, 1'b1);
        tx_frame(8'h4B, 1'b1, 1'b0);

        // random receive
        for (int k = 0; k < 24; k++) begin
            d = 8'($urandom);
            bad = 1'($urandom);
            err_sig_en = 1'($urandom);
            card_send(d, bad, -1);
            chk("R5", "rand data", int'(rx_data), int'(d));
            chk("R7", "rand perr", int'(parity_err), int'(bad));
            chk("R8", "rand pulse", int'(line_pull_low), int'(bad && err_sig_en));
            do_read();
            wait_ticks(20);
        end

        // random transmit
        for (int k = 0; k < 4; k++) tx_frame(8'($urandom), 1'b0, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule